// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a small on-chip memory that speaks a pipelined, zero-bus-turnaround SRAM protocol. Every command is decoded at one rising edge. The data belonging to it moves on the bus two enabled edges later: outgoing for a read, incoming for a write. Reads and writes can therefore follow each other on every cycle with no idle slot between them.

A two-bit burst counter lets a master continue an access without presenting a new address. The block also supports byte-lane writes, a pipeline-wide suspend through an active-low clock enable, deselect, and no-op cycles.

The shared bus is split into a data-in port, a data-out port and an output-enable. An outer wrapper can join these into a tri-state pad if one is needed.

Top module: `zbt_sram_core`

## Requirements
- R1: A read loaded at enabled edge k, with adv_ld low, the chip selected and wr_n high, drives dout_oe high and puts the stored word on dout after enabled edge k+2.
- R2: A write loaded at enabled edge k, with wr_n low, captures din at enabled edge k+2. Commands may alternate between read and write on consecutive cycles with no idle slot.
- R3: When adv_ld is high during an active burst, the two low address bits step by one and wrap modulo 4, while the upper address bits stay fixed. The access direction is the one latched at the load cycle, and wr_n is ignored.
- R4: The chip is selected only when ce1_n=0, ce2_n=0 and ce2=1. With adv_ld low and any of these three false, a deselect is issued, and dout_oe is low after the second enabled edge that follows it.
- R5: With adv_ld high after a deselect, the cycle is a no-op: no memory changes, and dout_oe is low two enabled edges later.
- R6: When cke_n is high at an edge, that edge has no effect. The memory, the burst state, the pipeline, dout and dout_oe all keep their values.
- R7: bw_n[i] is active low and gates lane i, which is data bits [9i+8:9i]. At the data edge of a write, any mix of lanes may be written. A write with every bw_n bit high leaves the memory unchanged.
- R8: After reset, dout_oe is low.
- R9: A read issued right after a write to the same address, in the next command or the one after it, returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high suspends the edge |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| adv_ld | input | 1 | Low: load new address; high: advance burst |
| wr_n | input | 1 | At load: low = write, high = read |
| bw_n | input | LANES | Active-low byte-lane write enables, sampled at data edge |
| addr | input | ADDR_W | Word address |
| din | input | 9*LANES | Write data, sampled two edges after command |
| dout | output | 9*LANES | Read data |
| dout_oe | output | 1 | High while dout is driven onto the bus |

## Verification
Every result is due two enabled edges after the command that causes it. Reads and the output-enable change after that edge, and write data together with its lane enables is taken at that edge. The bench keeps a two-entry model of pending commands that moves only on edges with cke_n low, so suspended cycles delay each expectation instead of consuming it. Inputs are driven on the falling edge and dout/dout_oe are compared on the following falling edge. Each comparison is tagged with the requirement of the command now at its data stage.

// File: rtl/zbt_pkg.sv
// Shared constants and types for the zero-turnaround SRAM core.
// Assumes lanes of eight data bits plus one parity bit each.
package zbt_pkg;
    localparam int LANE_W  = 9;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/zbt_cmd_ctrl.sv
// Command decoder and burst counter.
// Presents the command issued at the coming edge: a load, a burst step or idle.
// Assumes ADDR_W > BURST_W. State moves only on edges with cke_n low.
module zbt_cmd_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);
    logic              burst_on;
    logic              burst_wr;
    logic [ADDR_W-1:0] burst_addr;
    logic [ADDR_W-1:0] step_addr;

    // next burst address: low bits wrap, upper bits held
    assign step_addr = {burst_addr[ADDR_W-1:BURST_W],
                        burst_addr[BURST_W-1:0] + BURST_W'(1)};

    // decode the command presented at this edge
    always_comb begin
        cmd_op   = OP_IDLE;
        cmd_addr = addr;
        if (!adv_ld) begin
            if (sel) cmd_op = wr_n ? OP_READ : OP_WRITE;
        end else if (burst_on) begin
            cmd_op   = burst_wr ? OP_WRITE : OP_READ;
            cmd_addr = step_addr;
        end
    end

    // burst state: latched at load, stepped on advance, cleared by deselect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_on   <= 1'b0;
            burst_wr   <= 1'b0;
            burst_addr <= '0;
        end else if (!cke_n) begin
            if (!adv_ld) begin
                burst_on <= sel;
                if (sel) begin
                    burst_wr   <= !wr_n;
                    burst_addr <= addr;
                end
            end else if (burst_on) begin
                burst_addr <= step_addr;
            end
        end
    end
endmodule

// File: rtl/zbt_pipe.sv
// Two-stage command pipeline between the issue edge and the data edge.
// Assumes the stages freeze whenever cke_n is high.
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr
);
    // shift the command one stage per enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
        end else if (!cke_n) begin
            s1_op   <= cmd_op;
            s1_addr <= cmd_addr;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
        end
    end
endmodule

// File: rtl/zbt_lane_array.sv
// Storage split into independent byte lanes.
// One write port with per-lane enables, one combinational read port.
// Assumes the memory content is not reset.
module zbt_lane_array
    import zbt_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        wlane,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // write one lane when enabled
        always_ff @(posedge clk) begin
            if (we && wlane[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // read one lane
        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/zbt_sram_core.sv
// Top level of the pipelined zero-turnaround SRAM.
// The array is read one edge early into a buffer. A write at its data edge
// is forwarded lane by lane into that buffer.
// Assumes synchronous active-low reset and a single clock.
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    ce1_n,
    input  logic                    ce2_n,
    input  logic                    ce2,
    input  logic                    adv_ld,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DW = LANES * LANE_W;

    logic              sel;
    op_e               cmd_op, s1_op, s2_op;
    logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr;
    logic [DW-1:0]     arr_rdata, merged, rbuf;
    logic              fwd_hit;
    logic              arr_we;

    assign sel = !ce1_n && !ce2_n && ce2;

    zbt_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel(sel),
        .adv_ld(adv_ld), .wr_n(wr_n), .addr(addr),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr)
    );

    zbt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_op(s2_op), .s2_addr(s2_addr)
    );

    assign arr_we = !cke_n && (s2_op == OP_WRITE);

    zbt_lane_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(arr_we), .wlane(~bw_n), .waddr(s2_addr),
        .wdata(din), .raddr(s1_addr), .rdata(arr_rdata)
    );

    assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

    // lane-wise forward of the write landing at this edge
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] = (fwd_hit && !bw_n[g])
            ? din[g*LANE_W +: LANE_W] : arr_rdata[g*LANE_W +: LANE_W];
    end

    // read buffer, output data and output enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf    <= '0;
            dout    <= '0;
            dout_oe <= 1'b0;
        end else if (!cke_n) begin
            rbuf    <= merged;
            dout_oe <= (s2_op == OP_READ);
            if (s2_op == OP_READ) dout <= rbuf;
        end
    end
endmodule

// File: rtl/zbt_sram_chk.sv
// Protocol checker bound to zbt_sram_core.
// Checks the timing of the output enable and the freeze on suspend.
module zbt_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          ce1_n,
    input logic          ce2_n,
    input logic          ce2,
    input logic          adv_ld,
    input logic          wr_n,
    input logic [DW-1:0] dout,
    input logic          dout_oe
);
    logic chip_sel;
    assign chip_sel = !ce1_n && !ce2_n && ce2;

    assert_read_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && chip_sel && wr_n) ##1 !cke_n ##1 !cke_n |=> dout_oe);

    assert_write_no_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && chip_sel && !wr_n) ##1 !cke_n ##1 !cke_n |=> !dout_oe);

    assert_deselect_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !chip_sel) ##1 !cke_n ##1 !cke_n |=> !dout_oe);

    assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout_oe) && $stable(dout)));
endmodule

bind zbt_sram_core zbt_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .ce2(ce2), .adv_ld(adv_ld), .wr_n(wr_n), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_zbt_sram_core.sv
// Self-checking bench: a two-stage command model plus a memory model.
// Random traffic with a fixed seed and several directed corner cases.
module test_zbt_sram_core;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int DW = LN * 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_n = 1'b0, ce1_n = 1'b1, ce2_n = 1'b0, ce2 = 1'b1;
    logic adv_ld = 1'b0, wr_n = 1'b1;
    logic [LN-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    zbt_sram_core #(.LANES(LN), .ADDR_W(AW)) i_zbt_sram_core (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .ce2(ce2), .adv_ld(adv_ld), .wr_n(wr_n), .bw_n(bw_n), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #5 clk = ~clk;

    // model state: op 0 idle, 1 read, 2 write
    logic [DW-1:0] mm [1 << AW];
    int p1_op = 0, p2_op = 0;
    logic [AW-1:0] p1_a = '0, p2_a = '0;
    string p1_t = "R8", p2_t = "R8", chk_t = "R8";
    bit b_on = 0, b_wr = 0;
    logic [AW-1:0] b_a = '0;
    bit exp_oe = 0;
    logic [DW-1:0] exp_do = '0;

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                            logic [LN-1:0] bwn);
        logic [DW-1:0] r = old;
        for (int i = 0; i < LN; i++) if (!bwn[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic check(bit c, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!c) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, update model, check at next falling edge
    task automatic cyc(bit ck, bit adv, logic [2:0] ce, bit wn,
                       logic [AW-1:0] a, logic [LN-1:0] bw, logic [DW-1:0] d, string tg);
        bit s;
        cke_n = ck; adv_ld = adv; {ce1_n, ce2_n, ce2} = ce; wr_n = wn;
        addr = a; bw_n = bw; din = d;
        s = (ce == 3'b001);
        if (!ck) begin
            chk_t = p2_t;
            if (p2_op == 1) begin exp_oe = 1; exp_do = mm[p2_a]; end
            else begin
                exp_oe = 0;
                if (p2_op == 2) mm[p2_a] = merge(mm[p2_a], d, bw);
            end
            p2_op = p1_op; p2_a = p1_a; p2_t = p1_t;
            if (!adv) begin
                if (s) begin
                    p1_op = wn ? 1 : 2; p1_a = a;
                    p1_t = (tg != "") ? tg : (wn ? "R1" : "R2");
                    b_on = 1; b_wr = !wn; b_a = a;
                end else begin
                    p1_op = 0; p1_t = (tg != "") ? tg : "R4"; b_on = 0;
                end
            end else if (b_on) begin
                b_a = {b_a[AW-1:2], b_a[1:0] + 2'd1};
                p1_op = b_wr ? 2 : 1; p1_a = b_a;
                p1_t = (tg != "") ? tg : "R3";
            end else begin
                p1_op = 0; p1_t = (tg != "") ? tg : "R5";
            end
        end else chk_t = "R6";
        @(negedge clk);
        check(dout_oe === exp_oe, {chk_t, " oe"}, DW'(dout_oe), DW'(exp_oe));
        if (exp_oe) check(dout === exp_do, {chk_t, " data"}, dout, exp_do);
    endtask

    task automatic ld(bit wn, logic [AW-1:0] a, logic [LN-1:0] bw, logic [DW-1:0] d, string tg);
        cyc(0, 0, 3'b001, wn, a, bw, d, tg);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] w;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: bus released after reset
        check(dout_oe === 1'b0, "R8 reset oe", DW'(dout_oe), '0);
        // fill every address
        for (int i = 0; i < (1 << AW); i++) ld(0, AW'(i), '0, {$urandom, $urandom}, "R2");
        cyc(0, 0, 3'b101, 0, '0, '1, '0, "");
        cyc(0, 0, 3'b101, 0, '0, '1, '0, "");
        // back-to-back read/write alternation, R1/R2
        for (int i = 0; i < 8; i++) ld(i[0], AW'(i * 5), '0, {$urandom, $urandom}, "");
        // R9: read right after write, and one command later
        ld(0, 6'd9, '0, 36'h123456789, "R9");
        ld(1, 6'd9, '1, '0, "R9");
        ld(0, 6'd10, '0, 36'hABCDEF012, "R9");
        ld(0, 6'd11, '0, '0, "R9");
        ld(1, 6'd10, '1, '0, "R9");
        // R7: partial lanes, then a no-lane write, then read back
        ld(0, 6'd20, '0, 36'h111111111, "R7");
        ld(0, 6'd20, '0, '0, "R7");
        ld(0, 6'd20, '1, 36'h222222222, "R7");
        ld(1, 6'd20, 4'b1010, 36'hFEDCBA987, "R7");
        ld(1, 6'd20, '1, 36'h333333333, "R7");
        cyc(0, 1, 3'b001, 0, '0, '1, '0, "R7");
        // R3: write burst from offset 2 wraps; wr_n toggled during advance
        ld(0, 6'd42, '0, '0, "R3");
        cyc(0, 1, 3'b001, 1, 6'd0, '0, 36'h000000AAA, "R3");
        cyc(0, 1, 3'b001, 0, 6'd63, '0, 36'h000000BBB, "R3");
        cyc(0, 1, 3'b001, 1, 6'd5, '0, 36'h000000CCC, "R3");
        ld(1, 6'd41, '0, 36'h000000DDD, "R3");
        cyc(0, 1, 3'b001, 0, '0, '1, '0, "R3");
        cyc(0, 1, 3'b001, 0, '0, '1, '0, "R3");
        cyc(0, 1, 3'b001, 0, '0, '1, '0, "R3");
        // R4/R5: each false enable deselects; advance afterwards is a no-op
        ld(1, 6'd3, '1, '0, "");
        cyc(0, 0, 3'b101, 1, '0, '1, '0, "R4");
        cyc(0, 0, 3'b011, 0, '0, '0, '0, "R4");
        cyc(0, 0, 3'b000, 0, '0, '0, '0, "R4");
        cyc(0, 1, 3'b001, 0, '0, '0, 36'h5A5A5A5A5, "R5");
        cyc(0, 1, 3'b001, 1, '0, '0, 36'h5A5A5A5A5, "R5");
        cyc(0, 1, 3'b001, 1, '0, '0, 36'h5A5A5A5A5, "R5");
        ld(1, 6'd3, '1, '0, "R5");
        // R6: suspend in mid pipeline of a read and a write
        ld(1, 6'd7, '1, '0, "R6");
        ld(0, 6'd8, '1, '0, "R6");
        cyc(1, 0, 3'b001, 0, 6'd7, '0, 36'hBADBADBAD, "R6");
        cyc(1, 0, 3'b101, 1, 6'd7, '0, 36'hBADBADBAD, "R6");
        ld(1, 6'd8, '0, 36'h0F0F0F0F0, "R6");
        ld(1, 6'd7, '1, 36'h00000000F, "R6");
        cyc(1, 1, 3'b001, 0, '0, '0, 36'hBADBADBAD, "R6");
        cyc(0, 1, 3'b001, 1, '0, '1, '0, "R6");
        cyc(0, 0, 3'b101, 1, '0, '1, '0, "R6");
        // random traffic
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] ce;
            ce = ($urandom % 10 < 8) ? 3'b001 : 3'($urandom);
            w = {$urandom, $urandom};
            cyc(($urandom % 10) == 0, ($urandom % 10) < 3, ce, $urandom,
                AW'($urandom), LN'($urandom), w, "");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule